// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit with Overflow Extension

This block is a pipelined fixed-point multiplier and accumulator. Each cycle it accepts two 64-bit operands and an operation code. The operation is either a single signed multiply of the low 32-bit words or four independent signed multiplies of the 16-bit lanes. Products go straight to the result port, or into a bank of four 32-bit accumulator words. The words are used as two 64-bit pairs, or together as one 128-bit group. A shared 32-bit extension word holds the bits that accumulation pushes beyond 64 bits. Together with the selected pair it acts as a 96-bit running sum.

Two exchange operations make streaming accumulation cheap. In one issue slot they return the current contents of a pair, with its extension word and an overflow flag, and then restart or continue that same pair with the new product. A filter loop can therefore drain one finished sum and seed the next one without losing a cycle.

The pipeline has two stages. A result appears exactly two cycles after its issue. Accumulator state is updated in that same second stage, so operations may be issued every cycle and each one sees the result of the one before it.

Top module: `mac_unit`

## Requirements
- R1: Opcode 0 returns the low 32 bits of the signed product of the low 32-bit words of both operands in result bits [31:0]. All other result bits are zero.
- R2: Opcode 1 returns the full 64-bit signed product of the low 32-bit words in result bits [63:0]. The upper result bits are zero.
- R3: Opcode 2 multiplies each 16-bit lane i (bits [16i+15:16i]) of the two operands as signed values. It returns bits [30:15] of each product, rounded to nearest by adding 2^14 first, in result lane i. Values above 32767 saturate to 0x7FFF and values below -32768 saturate to 0x8000. Result bits above 63 are zero.
- R4: Opcode 3 returns the four full 32-bit signed lane products, with lane i in result bits [32i+31:32i].
- R5: Opcode 4 loads the 64-bit product of R2 into the selected pair and clears the extension word. The select input chooses the pair: 0 selects words 1:0 and 1 selects words 3:2, with the higher word holding the upper half. Opcode 4 produces no result.
- R6: Opcode 5 adds the sign-extended 64-bit product to the 96-bit value formed by {extension, selected pair}. It writes the sum back into both and produces no result.
- R7: Opcode 6 returns the pre-issue selected pair in result bits [63:0]. It returns the pre-issue extension word on the extension output. The overflow output is high when that extension word is not the sign extension of bit 63 of that pair. Opcode 6 then performs the load of R5.
- R8: Opcode 7 returns the same readout as R7 and then performs the accumulation of R6.
- R9: Opcode 8 loads lane product i (R4) into accumulator word i and clears the extension word. Opcode 9 returns the pre-issue words, with word i in result bits [32i+31:32i] and the extension word on the extension output, and then performs the same load.
- R10: Results are valid exactly two cycles after issue. Issues may come on every cycle without stalls, and each accumulation sees the state left by the operation issued one cycle earlier.
- R11: Opcodes 10 to 15, and any cycle with the issue strobe low, change no state and produce no result.
- R12: After reset the result valid output is low and all accumulator and extension words are zero.
- R13: A pair operation changes only the pair selected for it. The other pair keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 4 | Operation code (see requirements) |
| acc_sel | input | 1 | Pair select: 0 for words 1:0, 1 for words 3:2 |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| res_valid | output | 1 | Result outputs carry a result |
| res_data | output | 128 | Product, packed products or accumulator readout |
| res_ext | output | 32 | Extension word read out by an exchange operation |
| res_ovf | output | 1 | Pair readout does not fit in 64 signed bits |

## Verification
The hardest state to reach from the ports is an extension word that is neither zero nor all ones. Only accumulation beyond the 64-bit range produces it. The stimulus loads the largest positive 32x32 product (2^62) and adds it three more times on consecutive cycles, so the 96-bit sum carries exactly into the extension word. An exchange then reads the overflow flag. A separate sequence subtracts past zero to check that a negative sum fills the extension word with ones but does not raise the flag. A long mixed run of back-to-back operations on both pairs and the group follows. It is compared against a model kept inside the bench.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int LANE_W  = 16;
  localparam int NLANES  = 4;
  localparam int WORD_W  = 2 * LANE_W;
  localparam int OPND_W  = NLANES * LANE_W;
  localparam int PAIR_W  = 2 * WORD_W;
  localparam int EXT_W   = WORD_W;
  localparam int SUM_W   = PAIR_W + EXT_W;
  localparam int RES_W   = NLANES * WORD_W;
  localparam int NACC    = NLANES;
  localparam int OP_W    = 4;
  localparam int Q_SHIFT = LANE_W - 1;
  localparam int SHR_W   = WORD_W - Q_SHIFT + 1;

  typedef enum logic [OP_W-1:0] {
    OP_MUL32  = 4'd0,
    OP_MUL64  = 4'd1,
    OP_QMUL16 = 4'd2,
    OP_QMUL32 = 4'd3,
    OP_LOAD   = 4'd4,
    OP_MAC    = 4'd5,
    OP_XLOAD  = 4'd6,
    OP_XMAC   = 4'd7,
    OP_LOADQ  = 4'd8,
    OP_XQ     = 4'd9
  } mac_op_e;

  typedef struct packed {
    logic                           vld;
    logic [OP_W-1:0]                op;
    logic                           sel;
    logic [PAIR_W-1:0]              wide;
    logic [NLANES-1:0][WORD_W-1:0]  lane;
  } mul_stage_t;

  // Keep product bits [30:15] with round-to-nearest and saturation.
  function automatic logic [LANE_W-1:0] q15_round_sat(input logic [WORD_W-1:0] prod);
    logic [WORD_W:0]  biased;
    logic [SHR_W-1:0] kept;
    logic             fits;
    biased = {prod[WORD_W-1], prod} + {{SHR_W{1'b0}}, 1'b1, {(Q_SHIFT-1){1'b0}}};
    kept   = biased[WORD_W:Q_SHIFT];
    fits   = (&kept[SHR_W-1:LANE_W-1]) | ~(|kept[SHR_W-1:LANE_W-1]);
    if (fits) begin
      return kept[LANE_W-1:0];
    end else if (kept[SHR_W-1]) begin
      return {1'b1, {(LANE_W-1){1'b0}}};
    end else begin
      return {1'b0, {(LANE_W-1){1'b1}}};
    end
  endfunction

  function automatic logic op_defined(input logic [OP_W-1:0] op);
    return op <= OP_XQ;
  endfunction

  function automatic logic op_has_result(input logic [OP_W-1:0] op);
    case (op)
      OP_MUL32, OP_MUL64, OP_QMUL16, OP_QMUL32, OP_XLOAD, OP_XMAC, OP_XQ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic op_loads_pair(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_XLOAD);
  endfunction

  function automatic logic op_accumulates(input logic [OP_W-1:0] op);
    return (op == OP_MAC) || (op == OP_XMAC);
  endfunction

  function automatic logic op_loads_group(input logic [OP_W-1:0] op);
    return (op == OP_LOADQ) || (op == OP_XQ);
  endfunction

  function automatic logic op_reads_pair(input logic [OP_W-1:0] op);
    return (op == OP_XLOAD) || (op == OP_XMAC);
  endfunction

endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic              acc_sel,
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  output mul_stage_t        s1_q
);

  logic signed [PAIR_W-1:0]      a_ext, b_ext;
  logic [PAIR_W-1:0]             wide_prod;
  logic [NLANES-1:0][WORD_W-1:0] lane_prod;
  mul_stage_t                    s1_d;

  assign a_ext     = {{(PAIR_W-WORD_W){opnd_a[WORD_W-1]}}, opnd_a[WORD_W-1:0]};
  assign b_ext     = {{(PAIR_W-WORD_W){opnd_b[WORD_W-1]}}, opnd_b[WORD_W-1:0]};
  assign wide_prod = a_ext * b_ext;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    logic signed [WORD_W-1:0] la, lb;
    assign la = {{(WORD_W-LANE_W){opnd_a[g*LANE_W+LANE_W-1]}}, opnd_a[g*LANE_W +: LANE_W]};
    assign lb = {{(WORD_W-LANE_W){opnd_b[g*LANE_W+LANE_W-1]}}, opnd_b[g*LANE_W +: LANE_W]};
    assign lane_prod[g] = la * lb;
  end

  always_comb begin
    s1_d.vld  = issue_valid;
    s1_d.op   = issue_op;
    s1_d.sel  = acc_sel;
    s1_d.wide = wide_prod;
    s1_d.lane = lane_prod;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
    end else begin
      s1_q <= s1_d;
    end
  end

  AST_STAGE_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> s1_q.vld); // R10

endmodule

// File: rtl/mac_result_fmt.sv
module mac_result_fmt
  import mac_pkg::*;
(
  input  logic [OP_W-1:0]             op,
  input  logic [PAIR_W-1:0]           wide,
  input  logic [NLANES-1:0][WORD_W-1:0] lane,
  output logic [RES_W-1:0]            direct_res
);

  logic [NLANES-1:0][LANE_W-1:0] q_lane;

  for (genvar g = 0; g < NLANES; g++) begin : g_q
    assign q_lane[g] = q15_round_sat(lane[g]);
  end

  always_comb begin
    direct_res = '0;
    case (op)
      OP_MUL32:  direct_res[WORD_W-1:0] = wide[WORD_W-1:0];
      OP_MUL64:  direct_res[PAIR_W-1:0] = wide;
      OP_QMUL16: direct_res[OPND_W-1:0] = q_lane;
      OP_QMUL32: direct_res             = lane;
      default:   direct_res             = '0;
    endcase
  end

endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
  import mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  mul_stage_t       s1_q,
  input  logic [RES_W-1:0] direct_res,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data,
  output logic [EXT_W-1:0] res_ext,
  output logic             res_ovf
);

  localparam int HI_TOP = NACC - 1;
  localparam int HI_BOT = NACC - 2;

  logic [NACC-1:0][WORD_W-1:0] acc_q, acc_d;
  logic [EXT_W-1:0]            ext_q, ext_d;
  logic [PAIR_W-1:0]           pair_old, pair_new;
  logic [SUM_W-1:0]            acc_sum;
  logic                        old_ovf;

  // Named internal events
  logic ev_load_pair, ev_acc_pair, ev_load_group;
  logic ev_pair_read, ev_group_read, ev_undef, ev_result;

  assign ev_load_pair  = s1_q.vld && op_loads_pair(s1_q.op);
  assign ev_acc_pair   = s1_q.vld && op_accumulates(s1_q.op);
  assign ev_load_group = s1_q.vld && op_loads_group(s1_q.op);
  assign ev_pair_read  = s1_q.vld && op_reads_pair(s1_q.op);
  assign ev_group_read = s1_q.vld && (s1_q.op == OP_XQ);
  assign ev_undef      = s1_q.vld && !op_defined(s1_q.op);
  assign ev_result     = s1_q.vld && op_has_result(s1_q.op);

  assign pair_old = s1_q.sel ? acc_q[HI_TOP:HI_BOT] : acc_q[1:0];
  assign acc_sum  = {ext_q, pair_old} + {{EXT_W{s1_q.wide[PAIR_W-1]}}, s1_q.wide};
  assign old_ovf  = (ext_q != {EXT_W{pair_old[PAIR_W-1]}});
  assign pair_new = ev_acc_pair ? acc_sum[PAIR_W-1:0] : s1_q.wide;

  always_comb begin
    acc_d = acc_q;
    ext_d = ext_q;
    if (ev_load_pair || ev_acc_pair) begin
      if (s1_q.sel) begin
        acc_d[HI_TOP:HI_BOT] = pair_new;
      end else begin
        acc_d[1:0] = pair_new;
      end
      ext_d = ev_acc_pair ? acc_sum[SUM_W-1:PAIR_W] : '0;
    end else if (ev_load_group) begin
      acc_d = s1_q.lane;
      ext_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      ext_q     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_ext   <= '0;
      res_ovf   <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      ext_q     <= ext_d;
      res_valid <= ev_result;
      if (ev_pair_read) begin
        res_data <= {{(RES_W-PAIR_W){1'b0}}, pair_old};
        res_ext  <= ext_q;
        res_ovf  <= old_ovf;
      end else if (ev_group_read) begin
        res_data <= acc_q;
        res_ext  <= ext_q;
        res_ovf  <= 1'b0;
      end else begin
        res_data <= direct_res;
        res_ext  <= '0;
        res_ovf  <= 1'b0;
      end
    end
  end

  AST_UNDEF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_undef |=> ($stable(acc_q) && $stable(ext_q) && !res_valid)); // R11

  AST_OTHER_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_load_pair || ev_acc_pair) && !s1_q.sel) |=> $stable(acc_q[HI_TOP:HI_BOT])); // R13

  AST_EXT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_load_pair || ev_load_group) |=> (ext_q == '0)); // R5

  AST_READ_OLD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pair_read |=> (res_valid && res_data[PAIR_W-1:0] == $past(pair_old)
                      && res_ext == $past(ext_q))); // R7

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic              acc_sel,
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  output logic              res_valid,
  output logic [RES_W-1:0]  res_data,
  output logic [EXT_W-1:0]  res_ext,
  output logic              res_ovf
);

  mul_stage_t       s1_q;
  logic [RES_W-1:0] direct_res;

  mac_mul_stage u_mul (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_op    (issue_op),
    .acc_sel     (acc_sel),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .s1_q        (s1_q)
  );

  mac_result_fmt u_fmt (
    .op         (s1_q.op),
    .wide       (s1_q.wide),
    .lane       (s1_q.lane),
    .direct_res (direct_res)
  );

  mac_acc_bank u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .s1_q       (s1_q),
    .direct_res (direct_res),
    .res_valid  (res_valid),
    .res_data   (res_data),
    .res_ext    (res_ext),
    .res_ovf    (res_ovf)
  );

  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(issue_valid, 2)); // R10

endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  import mac_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         issue_valid = 1'b0;
  logic [3:0]   issue_op = '0;
  logic         acc_sel = 1'b0;
  logic [63:0]  opnd_a = '0;
  logic [63:0]  opnd_b = '0;
  logic         res_valid;
  logic [127:0] res_data;
  logic [31:0]  res_ext;
  logic         res_ovf;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .acc_sel(acc_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .res_valid(res_valid), .res_data(res_data), .res_ext(res_ext), .res_ovf(res_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [127:0] data;
    logic [31:0]  ext;
    logic         ovf;
    int           cyc;
  } exp_t;

  exp_t        q[$];
  string       tq[$];
  logic [31:0] m_acc [4];
  logic [31:0] m_ext;
  int          checks = 0;
  int          fails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_q15(input int p);
    int r;
    r = (p + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r[15:0];
  endfunction

  function automatic logic [63:0] m_pair(input bit sel);
    return sel ? {m_acc[3], m_acc[2]} : {m_acc[1], m_acc[0]};
  endfunction

  task automatic set_pair(input bit sel, input logic [63:0] v);
    if (sel) begin m_acc[3] = v[63:32]; m_acc[2] = v[31:0]; end
    else     begin m_acc[1] = v[63:32]; m_acc[0] = v[31:0]; end
  endtask

  // Driver: computes the expected item from the requirements and issues the op.
  task automatic issue(input logic [3:0] op, input bit sel, input logic [63:0] a,
                       input logic [63:0] b, input string tag);
    longint      w;
    logic [63:0] wide, old;
    logic [31:0] lp [4];
    logic [15:0] lq [4];
    logic [95:0] s;
    exp_t        e;
    bit          has;
    w = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
    wide = w;
    for (int i = 0; i < 4; i++) begin
      int p;
      p = int'($signed(a[16*i +: 16])) * int'($signed(b[16*i +: 16]));
      lp[i] = p;
      lq[i] = exp_q15(p);
    end
    old = m_pair(sel);
    e = '0;
    has = 1'b1;
    case (op)
      4'd0: e.data[31:0] = wide[31:0];
      4'd1: e.data[63:0] = wide;
      4'd2: for (int i = 0; i < 4; i++) e.data[16*i +: 16] = lq[i];
      4'd3: for (int i = 0; i < 4; i++) e.data[32*i +: 32] = lp[i];
      4'd6, 4'd7: begin
        e.data[63:0] = old;
        e.ext = m_ext;
        e.ovf = (m_ext != {32{old[63]}});
      end
      4'd9: begin
        e.data = {m_acc[3], m_acc[2], m_acc[1], m_acc[0]};
        e.ext = m_ext;
      end
      default: has = 1'b0;
    endcase
    case (op)
      4'd4, 4'd6: begin set_pair(sel, wide); m_ext = '0; end
      4'd5, 4'd7: begin
        s = {m_ext, old} + {{32{wide[63]}}, wide};
        set_pair(sel, s[63:0]);
        m_ext = s[95:64];
      end
      4'd8, 4'd9: begin
        for (int i = 0; i < 4; i++) m_acc[i] = lp[i];
        m_ext = '0;
      end
      default: ;
    endcase
    @(negedge clk);
    issue_valid = 1'b1;
    issue_op    = op;
    acc_sel     = sel;
    opnd_a      = a;
    opnd_b      = b;
    if (has) begin
      e.cyc = cyc + 2;
      q.push_back(e);
      tq.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      issue_valid = 1'b0;
    end
  endtask

  // Monitor: pops expected items as results appear.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected result", res_data, '0);
      end else begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        check(res_data == e.data && res_ext == e.ext && res_ovf == e.ovf, t,
              $sformatf("result (ext act=%h exp=%h ovf act=%0b exp=%0b)",
                        res_ext, e.ext, res_ovf, e.ovf),
              res_data, e.data);
        check(cyc == e.cyc, "R10", "result latency cycle", 128'(cyc), 128'(e.cyc));
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    finish_run();
  end

  localparam logic [63:0] BIG = 64'h0000_0000_8000_0000;

  initial begin
    for (int i = 0; i < 4; i++) m_acc[i] = '0;
    m_ext = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R12", "valid during reset", 128'(res_valid), '0);
    rst_n = 1'b1;
    // R12: state after reset reads back as zero
    issue(4'd9, 1'b0, '0, '0, "R12");
    // R1
    issue(4'd0, 1'b0, 64'(-5), 64'd7, "R1");
    issue(4'd0, 1'b0, 64'h7fff_ffff, 64'h7fff_ffff, "R1");
    // R2
    issue(4'd1, 1'b0, BIG, BIG, "R2");
    issue(4'd1, 1'b0, 64'(123456789), 64'(-987654321), "R2");
    // R3: saturation, exact, round-up and round-to-zero lanes
    issue(4'd2, 1'b0, 64'hffff_0001_4000_8000, 64'h4000_4000_4000_8000, "R3");
    issue(4'd2, 1'b0, 64'h7fff_8000_c000_1234, 64'h7fff_7fff_c000_edcb, "R3");
    // R4
    issue(4'd3, 1'b0, 64'h8000_7fff_ffff_0003, 64'h8000_8000_0002_fffd, "R4");
    // R5, R6, R10: carry past 64 bits through back-to-back accumulation
    issue(4'd4, 1'b0, BIG, BIG, "R5");
    issue(4'd5, 1'b0, BIG, BIG, "R6");
    issue(4'd5, 1'b0, BIG, BIG, "R6");
    issue(4'd5, 1'b0, BIG, BIG, "R10");
    issue(4'd7, 1'b0, BIG, BIG, "R8");
    issue(4'd6, 1'b0, 64'd3, 64'd5, "R7");
    // R6: accumulation below zero fills the extension with ones, no overflow
    issue(4'd5, 1'b0, 64'(-20), 64'd1, "R6");
    issue(4'd6, 1'b0, 64'd9, 64'd9, "R6");
    // R13: loading pair 3:2 leaves pair 1:0 untouched
    issue(4'd4, 1'b1, 64'd1000, 64'd1000, "R13");
    issue(4'd6, 1'b0, 64'd2, 64'd2, "R13");
    issue(4'd6, 1'b1, 64'd4, 64'd4, "R13");
    // R11: undefined opcodes and idle cycles do nothing
    issue(4'd12, 1'b0, BIG, BIG, "R11");
    issue(4'd15, 1'b1, BIG, BIG, "R11");
    @(negedge clk);
    issue_valid = 1'b0;
    issue_op = 4'd4;
    opnd_a = 64'd77;
    opnd_b = 64'd77;
    issue(4'd7, 1'b0, '0, '0, "R11");
    issue(4'd7, 1'b1, '0, '0, "R11");
    // R9: group load and exchange
    issue(4'd8, 1'b0, 64'h0004_fffd_0100_8000, 64'h0004_0003_0100_8000, "R9");
    issue(4'd9, 1'b0, 64'h0002_0003_0005_0007, 64'h0002_0003_0005_0007, "R9");
    issue(4'd9, 1'b0, '0, '0, "R9");
    idle(3);
    // R10: mixed back-to-back stream over all defined operations
    for (int k = 0; k < 80; k++) begin
      issue(4'($urandom_range(0, 9)), 1'($urandom_range(0, 1)),
            {$urandom, $urandom}, {$urandom, $urandom}, "R10");
    end
    issue(4'd6, 1'b0, '0, '0, "R10");
    issue(4'd6, 1'b1, '0, '0, "R10");
    idle(5);
    check(q.size() == 0, "R10", "results outstanding at end", 128'(q.size()), '0);
    finish_run();
  end

endmodule